// File: doc/BRIEF.md
# Dual-Window Expansion Card Address Decoder

This block decides whether a bus cycle on a 68k-style processor bus belongs to an expansion card. The host may run in a 24-bit addressing mode, where the eight top address bits carry no meaning, or in a full 32-bit mode. Bit 3 of the function-code input says which mode the current cycle uses. The card connector lacks address lines A30 to A28. For this reason the decoder sees only A31 plus A27 to A0, and it must tell the card's window apart using those lines alone.

When the address strobe falls, the decoder compares the relevant address nibble with one of two tags, picked by the mode bit. On the next clock edge it registers an active-low card select, a flag naming the window that matched, and a 20-bit local offset. These values hold steady for the rest of the strobe. Interrupt-acknowledge cycles (the lower three function-code bits all high) never select the card. The decoder also works on hosts that only ever issue 32-bit cycles.

Top module: `xcard_addr_decode`

## Requirements
- R1: While rst is high at a clock edge, sel_n becomes 1, mode32 becomes 0 and offset becomes 0 after that edge.
- R2: With fc[3]=0 and addr_lo[23:20]=4'hE, the first clock edge at which as_n is sampled low drives sel_n to 0. A31 and addr_lo[27:24] have no effect on this (the 24-bit window $E0_0000 to $EF_FFFF).
- R3: With fc[3]=1, addr_a31=1 and addr_lo[23:20]=4'h0, the first edge with as_n low drives sel_n to 0. addr_lo[27:24] has no effect on this (the 32-bit window $FE00_0000 to $FE0F_FFFF).
- R4: Every other combination of fc[3], addr_a31 and addr_lo[23:20] leaves sel_n at 1 for the whole strobe.
- R5: When fc[2:0]=3'b111 (interrupt acknowledge), sel_n stays 1 even if the address falls in a window.
- R6: At the capturing edge, offset takes addr_lo[19:0]. mode32 becomes 1 only when the 32-bit window matched, and 0 otherwise.
- R7: While as_n stays low after the capturing edge, any change of address or function code leaves sel_n, mode32 and offset unchanged.
- R8: The first edge with as_n sampled high returns sel_n to 1 and keeps mode32 and offset. A single such edge between two strobes is enough for the next strobe to be decoded again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low |
| fc | input | 4 | Function code; bit 3 selects 32-bit mode |
| addr_a31 | input | 1 | Address bit 31 |
| addr_lo | input | 28 | Address bits 27 down to 0 |
| sel_n | output | 1 | Card select, active low, registered |
| mode32 | output | 1 | High when the captured cycle hit the 32-bit window |
| offset | output | 20 | Captured A19..A0 |

## Verification
The hardest case to reach is a strobe that stays low while the address and function code move under it. If the design re-decoded during the cycle, the select would drop or glitch. The stimulus therefore captures every cycle and then, in the following clock, swaps in an address and mode from the opposite class. After that it checks that all three outputs stay frozen. The decode itself is swept over every function code, both A31 values, all sixteen decode nibbles and several values of the ignored A27..A24 bits.

// File: rtl/xdec_pkg.sv
package xdec_pkg;
   typedef enum logic {MODE_24 = 1'b0, MODE_32 = 1'b1} bus_mode_e;

   // Function code 3'b111 on the low bits marks interrupt acknowledge
   function automatic logic is_iack(input logic [2:0] fc_low);
      return &fc_low;
   endfunction
endpackage

// File: rtl/xdec_window.sv
module xdec_window #(
   parameter int          TAG_W     = 4,
   parameter logic [TAG_W-1:0] TAG  = '0,
   parameter xdec_pkg::bus_mode_e WANT_MODE = xdec_pkg::MODE_24
) (
   input  logic             mode_bit,
   input  logic             a31,
   input  logic             iack,
   input  logic [TAG_W-1:0] tag_field,
   output logic             hit
);
   logic mode_ok, tag_ok, top_ok;

   assign mode_ok = (mode_bit == logic'(WANT_MODE));
   assign tag_ok  = (tag_field == TAG);

   generate
      if (WANT_MODE == xdec_pkg::MODE_32) begin : g_top_needed
         assign top_ok = a31;
      end else begin : g_top_ignored
         assign top_ok = 1'b1;
      end
   endgenerate

   assign hit = mode_ok & tag_ok & top_ok & ~iack;
endmodule

// File: rtl/xdec_capture.sv
module xdec_capture #(
   parameter int OFF_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             as_n,
   input  logic             hit24,
   input  logic             hit32,
   input  logic             iack,
   input  logic [OFF_W-1:0] off_in,
   output logic             sel_n,
   output logic             mode32,
   output logic [OFF_W-1:0] offset
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         sel_n  <= 1'b1;
         mode32 <= 1'b0;
         offset <= '0;
      end else if (as_n) begin
         busy_q <= 1'b0;
         sel_n  <= 1'b1;
      end else if (!busy_q) begin
         busy_q <= 1'b1;
         sel_n  <= ~(hit24 | hit32);
         mode32 <= hit32;
         offset <= off_in;
      end
   end

   // R1: reset state
   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (sel_n && !mode32 && offset == '0));

   // R5: interrupt acknowledge never selects
   p_iack_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      (!as_n && !busy_q && iack) |=> sel_n);

   // R6: mode flag rises only together with a select
   p_mode_with_sel_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(mode32) |-> !sel_n);

   // R7: outputs frozen for the rest of the strobe
   p_hold_in_cycle_r7: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !as_n) |=> ($stable(sel_n) && $stable(mode32) && $stable(offset)));

   // R8: strobe high releases select
   p_release_r8: assert property (@(posedge clk) disable iff (rst)
      as_n |=> sel_n);

   // R2/R3: two windows can never hit at once
   p_one_window: assert property (@(posedge clk) disable iff (rst)
      !(hit24 && hit32));
endmodule

// File: rtl/xcard_addr_decode.sv
module xcard_addr_decode #(
   parameter int        LO_W       = 28,
   parameter int        OFF_W      = 20,
   parameter int        DEC_TOP    = 24,
   parameter logic [3:0] TAG24     = 4'hE,
   parameter logic [3:0] TAG32     = 4'h0,
   parameter bit        SUPPORT_24 = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             as_n,
   input  logic [3:0]       fc,
   input  logic             addr_a31,
   input  logic [LO_W-1:0]  addr_lo,
   output logic             sel_n,
   output logic             mode32,
   output logic [OFF_W-1:0] offset
);
   localparam int TAG_W = DEC_TOP - OFF_W;

   generate
      if (TAG_W != 4) begin : g_bad_tag
         $error("decode field must be 4 bits wide");
      end
      if (LO_W <= DEC_TOP) begin : g_bad_lo
         $error("low address bus must reach above the decode field");
      end
   endgenerate

   logic             iack;
   logic             hit24, hit32;
   logic [TAG_W-1:0] tag_field;
   logic             unused_hi;

   assign iack      = xdec_pkg::is_iack(fc[2:0]);
   assign tag_field = addr_lo[DEC_TOP-1:OFF_W];
   assign unused_hi = ^addr_lo[LO_W-1:DEC_TOP];

   generate
      if (SUPPORT_24) begin : g_win24
         xdec_window #(
            .TAG_W(TAG_W), .TAG(TAG24[TAG_W-1:0]), .WANT_MODE(xdec_pkg::MODE_24)
         ) i_win24 (
            .mode_bit(fc[3]), .a31(addr_a31), .iack(iack),
            .tag_field(tag_field), .hit(hit24)
         );
      end else begin : g_no_win24
         assign hit24 = 1'b0;
      end
   endgenerate

   xdec_window #(
      .TAG_W(TAG_W), .TAG(TAG32[TAG_W-1:0]), .WANT_MODE(xdec_pkg::MODE_32)
   ) i_win32 (
      .mode_bit(fc[3]), .a31(addr_a31), .iack(iack),
      .tag_field(tag_field), .hit(hit32)
   );

   xdec_capture #(.OFF_W(OFF_W)) i_cap (
      .clk(clk), .rst(rst), .as_n(as_n),
      .hit24(hit24), .hit32(hit32), .iack(iack),
      .off_in(addr_lo[OFF_W-1:0]),
      .sel_n(sel_n), .mode32(mode32), .offset(offset)
   );
endmodule

// File: tb/test_xcard_addr_decode.sv
module test_xcard_addr_decode;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        as_n = 1'b1;
   logic [3:0]  fc = '0;
   logic        addr_a31 = 1'b0;
   logic [27:0] addr_lo = '0;
   logic        sel_n, mode32;
   logic [19:0] offset;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   xcard_addr_decode i_xcard_addr_decode (
      .clk(clk), .rst(rst), .as_n(as_n), .fc(fc), .addr_a31(addr_a31),
      .addr_lo(addr_lo), .sel_n(sel_n), .mode32(mode32), .offset(offset)
   );

   task automatic chk(input string req, input logic [21:0] act, input logic [21:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      #500000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got hang expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic        e_sel, e_mode;
      logic [19:0] e_off;
      int          n = 0;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk("R1", {sel_n, mode32, offset}, {1'b1, 1'b0, 20'h0});

      for (int f = 0; f < 16; f++) begin
         for (int t = 0; t < 2; t++) begin
            for (int nib = 0; nib < 16; nib++) begin
               for (int h = 0; h < 4; h++) begin
                  logic [3:0] hi;
                  logic       m24, m32;
                  string      rq;
                  hi = (h == 0) ? 4'h0 : (h == 1) ? 4'hF : (h == 2) ? 4'hE : 4'h5;
                  n++;
                  e_off = 20'((n * 40503) ^ (n << 7));
                  m24 = (f < 8) && (nib == 14) && ((f & 7) != 7);
                  m32 = (f >= 8) && (t == 1) && (nib == 0) && ((f & 7) != 7);
                  e_sel = ~(m24 | m32);
                  e_mode = m32;
                  rq = ((f & 7) == 7) ? "R5" : m24 ? "R2" : m32 ? "R3" : "R4";
                  // start strobe
                  fc = 4'(f); addr_a31 = 1'(t);
                  addr_lo = {hi, 4'(nib), e_off};
                  as_n = 1'b0;
                  @(negedge clk);
                  chk(rq, {1'b0, sel_n, 20'h0}, {1'b0, e_sel, 20'h0});
                  chk("R6", {1'b0, mode32, offset}, {1'b0, e_mode, e_off});
                  // disturb inputs mid-strobe
                  fc = ~fc; addr_a31 = ~addr_a31;
                  addr_lo = {~hi, (nib == 14) ? 4'h0 : 4'hE, ~e_off};
                  @(negedge clk);
                  chk("R7", {sel_n, mode32, offset}, {e_sel, e_mode, e_off});
                  // release for a single edge
                  as_n = 1'b1;
                  @(negedge clk);
                  chk("R8", {sel_n, mode32, offset}, {1'b1, e_mode, e_off});
               end
            end
         end
      end
      // R1: reset during a selected cycle
      fc = 4'h8; addr_a31 = 1'b1; addr_lo = 28'h7012345; as_n = 1'b0;
      @(negedge clk);
      chk("R3", {1'b0, sel_n, offset}, {1'b0, 1'b0, 20'h12345});
      rst = 1'b1;
      @(negedge clk);
      chk("R1", {sel_n, mode32, offset}, {1'b1, 1'b0, 20'h0});
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule